// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a watchdog peripheral on a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. A 64-bit up-counter is read and written as two 32-bit halves. It is compared against a 64-bit period that is split the same way. Software first sets the period, the enable mode and the global control word while the block is disabled. It then arms the watchdog by writing two 16-bit keys in a fixed order.

Once armed, software must repeat the same ordered key pair before the counter reaches the period. Each completed pair restarts the count from zero. From the first accepted key onward, every configuration register is frozen. If the counter reaches the period while the watchdog is armed, the block does three things: it raises a one-cycle reset request, it sets a sticky timeout flag, and it locks up until system reset.

Top module: `kwd_top`

## Requirements
- R1: After reset, the counter, period, timer control, global control and watchdog control all read 0, `reset_req` is low, and offset 0x00 reads the `ID_VALUE` parameter.
- R2: While disabled, these registers are writable and read back as follows:
  - counter halves at offsets 0x10 (low) and 0x14 (high);
  - period halves at 0x18 (low) and 0x1C (high);
  - timer control at 0x20, which keeps only bits 7:6;
  - global control at 0x24, which keeps only bits 3:0.
- R3: The counter advances by one per clock only when all of these hold:
  - timer control bits 7:6 are nonzero;
  - global control bits 0 and 1 are both 1;
  - the block has not timed out.

  The low half carries into the high half, and reads return the live count.
- R4: In the watchdog control word at 0x28, the key sits in bits 31:16 and the enable bit is bit 14. While disabled, a write of key 0xA5C6 with bit 14 set, with global control bits 3:2 equal to 2, enters pre-active. Any other write leaves the block disabled. Bit 14 reads 1 whenever the block is not disabled.
- R5: In pre-active, a write of key 0xDA7E with bit 14 set enters active and clears the counter to zero.
- R6: In active, key 0xA5C6 enters service. In service, key 0xDA7E returns to active and clears the counter to zero. Any other key leaves the state unchanged, and 0xDA7E alone in active does not clear the counter.
- R7: From pre-active onward, these writes are ignored:
  - writes to the counter, period, timer control and global control;
  - attempts to clear bit 14.
- R8: When the block is active or in service and the counter is at or above the period, the following happens on the next clock:
  - bit 15 of 0x28 is set;
  - `reset_req` is high for exactly one cycle;
  - the counter stops;
  - all keys are ignored until reset.
- R9: Writing 1 to bit 15 of 0x28 clears the timeout flag. A flag being set in the same cycle wins over the clear.
- R10: Offset 0x04 and unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| reset_req | output | 1 | One-cycle system reset request on timeout |

## Verification
Results fall due at three different times:
- A write takes effect on the edge at which it is sampled, so its read-back is due one edge after the write strobe.
- Read data is combinational, so it is valid in the same cycle as the address.
- The reset request and the timeout flag rise one edge after the cycle in which the counter first meets the period.

The bench drives inputs on falling edges. Its behavioural model advances on each rising edge. The bench compares the read data and `reset_req` against the model 1 ns after every rising edge, so each result is checked in exactly the cycle it is due. Directed checks read registers at chosen points. Where the exact cycle count is not part of a requirement, these checks compare relative values (stalled, advanced, restarted near zero).

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  typedef enum logic [2:0] {
    WD_OFF  = 3'd0,
    WD_PRE  = 3'd1,
    WD_ACT  = 3'd2,
    WD_SVC  = 3'd3,
    WD_DEAD = 3'd4
  } wd_state_e;

  localparam int OFS_ID    = 'h00;
  localparam int OFS_EMU   = 'h04;
  localparam int OFS_CNTLO = 'h10;
  localparam int OFS_CNTHI = 'h14;
  localparam int OFS_PRDLO = 'h18;
  localparam int OFS_PRDHI = 'h1C;
  localparam int OFS_TCR   = 'h20;
  localparam int OFS_GCR   = 'h24;
  localparam int OFS_WDC   = 'h28;

  localparam logic [15:0] KEY_ARM = 16'hA5C6;
  localparam logic [15:0] KEY_GO  = 16'hDA7E;

  localparam int BIT_EN   = 14;
  localparam int BIT_FLAG = 15;

  localparam logic [1:0] GCR_WDMODE = 2'd2;

  // counter advances only with a nonzero enable mode and both halves released
  function automatic logic gate_open(input logic [1:0] mode, input logic [3:0] gcr);
    return (mode != 2'd0) && gcr[0] && gcr[1];
  endfunction

  // timeout condition: count at or beyond period
  function automatic logic period_reached(input logic [63:0] cnt, input logic [63:0] prd);
    return cnt >= prd;
  endfunction

  function automatic logic is_armed(input wd_state_e s);
    return (s == WD_ACT) || (s == WD_SVC);
  endfunction

endpackage

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic                run,
  output logic [2*DATA_W-1:0] cnt
);
  localparam int CNT_W = 2 * DATA_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) cnt[DATA_W-1:0]     <= ld_data;
      if (ld_hi) cnt[CNT_W-1:DATA_W] <= ld_data;
    end else if (run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/kwd_keyfsm.sv
module kwd_keyfsm
  import kwd_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  input  logic             en_bit,
  input  logic             mode_ok,
  input  logic             hit,
  output wd_state_e        state,
  output logic             restart,
  output logic             reset_req
);
  wd_state_e nxt;

  always_comb begin
    nxt     = state;
    restart = 1'b0;
    case (state)
      WD_OFF: if (key_wr && en_bit && mode_ok && key == KEY_W'(KEY_ARM)) nxt = WD_PRE;
      WD_PRE: if (key_wr && en_bit && key == KEY_W'(KEY_GO)) begin
                nxt = WD_ACT; restart = 1'b1;
              end
      WD_ACT: if (key_wr && key == KEY_W'(KEY_ARM)) nxt = WD_SVC;
      WD_SVC: if (key_wr && key == KEY_W'(KEY_GO)) begin
                nxt = WD_ACT; restart = 1'b1;
              end
      default: nxt = WD_DEAD;
    endcase
    if (hit) begin
      nxt     = WD_DEAD;
      restart = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WD_OFF;
      reset_req <= 1'b0;
    end else begin
      state     <= nxt;
      reset_req <= hit;
    end
  end
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h5744_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int KEY_W = DATA_W / 2;

  wd_state_e          wd_state;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   prd_q;
  logic [1:0]         tcr_mode;
  logic [3:0]         gcr_q;
  logic               tmo_flag;
  logic               cfg_lock;
  logic               run;
  logic               hit;
  logic               restart;
  logic               cnt_ld;
  logic               prd_wr;

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_cntlo, wr_cnthi, wr_prdlo, wr_prdhi, wr_tcr, wr_gcr, wr_wdc;
  assign wr_cntlo = bus_we && sel(bus_addr, OFS_CNTLO);
  assign wr_cnthi = bus_we && sel(bus_addr, OFS_CNTHI);
  assign wr_prdlo = bus_we && sel(bus_addr, OFS_PRDLO);
  assign wr_prdhi = bus_we && sel(bus_addr, OFS_PRDHI);
  assign wr_tcr   = bus_we && sel(bus_addr, OFS_TCR);
  assign wr_gcr   = bus_we && sel(bus_addr, OFS_GCR);
  assign wr_wdc   = bus_we && sel(bus_addr, OFS_WDC);

  assign cfg_lock = (wd_state != WD_OFF);
  assign run      = gate_open(tcr_mode, gcr_q) && (wd_state != WD_DEAD);
  assign hit      = is_armed(wd_state) && period_reached(cnt_q, prd_q);
  assign cnt_ld   = !cfg_lock && (wr_cntlo || wr_cnthi);
  assign prd_wr   = wr_prdlo || wr_prdhi;

  kwd_keyfsm #(.KEY_W(KEY_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (wr_wdc),
    .key       (bus_wdata[DATA_W-1:KEY_W]),
    .en_bit    (bus_wdata[BIT_EN]),
    .mode_ok   (gcr_q[3:2] == GCR_WDMODE),
    .hit       (hit),
    .state     (wd_state),
    .restart   (restart),
    .reset_req (reset_req)
  );

  kwd_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (restart),
    .ld_lo   (!cfg_lock && wr_cntlo),
    .ld_hi   (!cfg_lock && wr_cnthi),
    .ld_data (bus_wdata),
    .run     (run),
    .cnt     (cnt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q    <= '0;
      tcr_mode <= '0;
      gcr_q    <= '0;
    end else if (!cfg_lock) begin
      if (wr_prdlo) prd_q[DATA_W-1:0]     <= bus_wdata;
      if (wr_prdhi) prd_q[CNT_W-1:DATA_W] <= bus_wdata;
      if (wr_tcr)   tcr_mode              <= bus_wdata[7:6];
      if (wr_gcr)   gcr_q                 <= bus_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              tmo_flag <= 1'b0;
    else if (hit)                            tmo_flag <= 1'b1;
    else if (wr_wdc && bus_wdata[BIT_FLAG])  tmo_flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if      (sel(bus_addr, OFS_ID))    bus_rdata = DATA_W'(ID_VALUE);
    else if (sel(bus_addr, OFS_CNTLO)) bus_rdata = cnt_q[DATA_W-1:0];
    else if (sel(bus_addr, OFS_CNTHI)) bus_rdata = cnt_q[CNT_W-1:DATA_W];
    else if (sel(bus_addr, OFS_PRDLO)) bus_rdata = prd_q[DATA_W-1:0];
    else if (sel(bus_addr, OFS_PRDHI)) bus_rdata = prd_q[CNT_W-1:DATA_W];
    else if (sel(bus_addr, OFS_TCR))   bus_rdata[7:6] = tcr_mode;
    else if (sel(bus_addr, OFS_GCR))   bus_rdata[3:0] = gcr_q;
    else if (sel(bus_addr, OFS_WDC)) begin
      bus_rdata[BIT_FLAG] = tmo_flag;
      bus_rdata[BIT_EN]   = cfg_lock;
    end
  end
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
  import kwd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input wd_state_e   state,
  input logic [63:0] cnt,
  input logic [63:0] prd,
  input logic        hit,
  input logic        restart,
  input logic        reset_req,
  input logic        tmo_flag,
  input logic        run,
  input logic        cnt_ld,
  input logic        prd_wr
);
  // R8
  rr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  // R8
  rr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (reset_req && tmo_flag && state == WD_DEAD));
  // R8
  dead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_DEAD) |=> (state == WD_DEAD));
  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == 64'd0));
  // R7
  prd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != WD_OFF && prd_wr) |=> $stable(prd));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart && !cnt_ld) |=> $stable(cnt));
  // R4
  arm_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_OFF) |=> (state == WD_OFF || state == WD_PRE));
endmodule

bind kwd_top kwd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (wd_state),
  .cnt       (cnt_q),
  .prd       (prd_q),
  .hit       (hit),
  .restart   (restart),
  .reset_req (reset_req),
  .tmo_flag  (tmo_flag),
  .run       (run),
  .cnt_ld    (cnt_ld),
  .prd_wr    (prd_wr)
);

// File: tb/kwd_top_bench.sv
module kwd_top_bench;
  localparam logic [31:0] IDV = 32'h5744_0101;
  localparam logic [15:0] K_A = 16'hA5C6;
  localparam logic [15:0] K_B = 16'hDA7E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rr;

  always #2 clk = ~clk;

  kwd_top u_kwd_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .reset_req(rr)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model: 0 off, 1 pre, 2 active, 3 service, 4 timed out
  int          m_st = 0;
  logic [63:0] m_cnt = '0, m_prd = '0;
  logic [1:0]  m_mode = '0;
  logic [3:0]  m_gcr = '0;
  bit          m_flag = 0, m_rr = 0;
  bit          b_run, b_hit, b_clr, b_lk, b_wdc;
  logic [15:0] b_key;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = '0; m_prd = '0; m_mode = '0; m_gcr = '0; m_flag = 0; m_rr = 0;
    end else begin
      b_lk  = (m_st != 0);
      b_run = (m_mode != 0) && m_gcr[0] && m_gcr[1] && (m_st != 4);
      b_hit = (m_st == 2 || m_st == 3) && (m_cnt >= m_prd);
      b_wdc = we && addr == 8'h28;
      b_key = wdata[31:16];
      b_clr = 0;
      if (b_hit) m_st = 4;
      else if (b_wdc) begin
        if (m_st == 0 && wdata[14] && m_gcr[3:2] == 2 && b_key == K_A) m_st = 1;
        else if (m_st == 1 && wdata[14] && b_key == K_B) begin m_st = 2; b_clr = 1; end
        else if (m_st == 2 && b_key == K_A) m_st = 3;
        else if (m_st == 3 && b_key == K_B) begin m_st = 2; b_clr = 1; end
      end
      if (b_clr) m_cnt = '0;
      else if (!b_lk && we && (addr == 8'h10 || addr == 8'h14)) begin
        if (addr == 8'h10) m_cnt[31:0] = wdata; else m_cnt[63:32] = wdata;
      end else if (b_run) m_cnt = m_cnt + 1;
      if (!b_lk && we) begin
        if (addr == 8'h18) m_prd[31:0]  = wdata;
        if (addr == 8'h1C) m_prd[63:32] = wdata;
        if (addr == 8'h20) m_mode       = wdata[7:6];
        if (addr == 8'h24) m_gcr        = wdata[3:0];
      end
      if (b_hit) m_flag = 1;
      else if (b_wdc && wdata[15]) m_flag = 0;
      m_rr = b_hit;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return IDV;
      8'h10: return m_cnt[31:0];
      8'h14: return m_cnt[63:32];
      8'h18: return m_prd[31:0];
      8'h1C: return m_prd[63:32];
      8'h20: return {24'd0, m_mode, 6'd0};
      8'h24: return {28'd0, m_gcr};
      8'h28: return {16'd0, m_flag, (m_st != 0), 14'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R1";
      8'h10, 8'h14: return "R3";
      8'h28: return "R8";
      8'h18, 8'h1C, 8'h20, 8'h24: return "R2";
      default: return "R10";
    endcase
  endfunction

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    chk(rr == m_rr, "R8 reset_req", 64'(rr), 64'(m_rr));
    chk(rdata == exp_rd(addr), tag_of(addr), 64'(rdata), 64'(exp_rd(addr)));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 1'b0;
    #1 v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, a0, b0;
    int pulses;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, v); chk(v == IDV, "R1 id", v, IDV);
    rd(8'h28, v); chk(v == 0, "R1 wdctl", v, 0);
    rd(8'h10, v); chk(v == 0, "R1 cnt", v, 0);
    // R2 field storage
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); chk(v == 32'hC0, "R2 tcr", v, 32'hC0);
    wr(8'h24, 32'hFFFF_FFF0); rd(8'h24, v); chk(v == 0, "R2 gcr", v, 0);
    wr(8'h24, 32'h3);         rd(8'h24, v); chk(v == 3, "R2 gcr", v, 3);
    // R3 gating
    wr(8'h20, 0); rd(8'h10, a0); idle(5); rd(8'h10, b0);
    chk(a0 == b0, "R3 stalled", b0, a0);
    wr(8'h20, 32'h80); rd(8'h10, a0); rd(8'h10, b0);
    chk(b0 == a0 + 1, "R3 advance", b0, a0 + 1);
    wr(8'h10, 32'hFFFF_FFFE); idle(4); rd(8'h14, v);
    chk(v == 1, "R3 carry", v, 1);
    // R4 arming conditions
    wr(8'h28, {K_A, 16'h4000}); rd(8'h28, v); chk(v == 0, "R4 mode not wd", v, 0);
    wr(8'h24, 32'hB);
    wr(8'h28, {K_A, 16'h0000}); rd(8'h28, v); chk(v == 0, "R4 no enable", v, 0);
    wr(8'h28, {16'h1234, 16'h4000}); rd(8'h28, v); chk(v == 0, "R4 bad key", v, 0);
    wr(8'h18, 32'd60); wr(8'h1C, 0);
    wr(8'h28, {K_A, 16'h4000}); rd(8'h28, v); chk(v == 32'h4000, "R4 preactive", v, 32'h4000);
    // R7 write protection
    wr(8'h18, 32'd5); rd(8'h18, v); chk(v == 60, "R7 period", v, 60);
    wr(8'h24, 0);     rd(8'h24, v); chk(v == 32'hB, "R7 gcr", v, 32'hB);
    wr(8'h20, 0);     rd(8'h20, v); chk(v == 32'h80, "R7 tcr", v, 32'h80);
    wr(8'h28, 0);     rd(8'h28, v); chk(v == 32'h4000, "R7 enable held", v, 32'h4000);
    // R5 activate
    wr(8'h28, {K_B, 16'h4000}); rd(8'h14, v); chk(v == 0, "R5 hi cleared", v, 0);
    rd(8'h10, v); chk(v < 4, "R5 restart", v, 3);
    // R6 service sequence
    idle(8); rd(8'h10, a0);
    wr(8'h28, {K_B, 16'h0}); rd(8'h10, b0); chk(b0 > a0, "R6 lone second key", b0, a0);
    wr(8'h28, {K_A, 16'h0}); wr(8'h28, {16'h5555, 16'h0});
    wr(8'h28, {K_B, 16'h0}); rd(8'h10, v); chk(v < 4, "R6 kick", v, 3);
    // R8 timeout
    pulses = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); if (rr) pulses++;
    end
    chk(pulses == 1, "R8 single pulse", pulses, 1);
    rd(8'h28, v); chk(v == 32'hC000, "R8 flag", v, 32'hC000);
    rd(8'h10, a0); idle(6); rd(8'h10, b0); chk(a0 == b0, "R8 frozen", b0, a0);
    wr(8'h28, {K_A, 16'h4000}); wr(8'h28, {K_B, 16'h4000});
    rd(8'h10, v); chk(v == a0, "R8 keys ignored", v, a0);
    // R9 clear flag
    wr(8'h28, 32'h8000); rd(8'h28, v); chk(v == 32'h4000, "R9 w1c", v, 32'h4000);
    // R10 unmapped
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk(v == 0, "R10 emu", v, 0);
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, v); chk(v == 0, "R10 hole", v, 0);
    rd(8'h08, v); chk(v == 0, "R10 gap", v, 0);
    idle(2);
    finish_run();
  end
endmodule